// File: doc/BRIEF.md
# Zero-Vector-Free Space-Vector PWM Sequencer

This block produces the upper-leg switch pattern of a two-level three-phase inverter bridge, one carrier period at a time. In every tick the bridge holds one of the six active switching states. The all-low and all-high states never appear, so the common-mode voltage stays at one third of its zero-vector peak. A controller upstream classifies the reference vector and computes the dwell times. It hands the sequencer a command that holds a region code, a zone, a sub-zone and three dwell times in clock ticks. The sequencer picks the active vectors for that region, sets their order, and plays them out symmetrically about the middle of the period.

Each region has its own vector set. The low-voltage region uses four vectors: an adjacent pair that forms the reference, plus an opposite pair that replaces the zero vector. The high-voltage region uses three neighbouring vectors. The over-voltage region uses either two adjacent vectors or a single clamped vector held for the whole period. A new command is captured at any time but takes effect only at the next period boundary. Besides the switch signals, the block outputs the vector index and a signed common-mode code.

Top module: `zvf_pwm_seq`

## Requirements
- R1: `sw_o` is never 3'b000 or 3'b111: exactly one or two bits are set in every cycle, reset included.
- R2: `vec_o` value v (0..5) stands for vector u(v+1). Bits {A,B,C} of `sw_o` are u1=100, u2=110, u3=010, u4=011, u5=001, u6=101. `cm_o` is 2'b01 (+1) for an even `vec_o` (one leg high) and 2'b11 (-1) for an odd `vec_o` (two legs high).
- R3: Region code 0 (low voltage) with zone z plays, from the period edges inward, indices z+5, z, z+1, z+2 (mod 6). Example: zone 0 gives u6, u1, u2, u3. `cmd_dw0`..`cmd_dw2` are the full-period dwells of the first three; the last vector takes the rest of the period.
- R4: Region code 1 (high voltage) plays indices z+5, z, z+1, so the nearest vector sits between its two neighbours. The dwells come from `cmd_dw0` and `cmd_dw1`, and `cmd_dw2` has no effect. Region code 3 behaves exactly as code 1.
- R5: Region code 2 (over voltage) depends on `cmd_sub`. Sub 0 plays indices z, z+1, with `cmd_dw0` as the dwell of index z. Sub 1 holds index z+1 for the whole period. Sub 2 and sub 3 hold index z for the whole period.
- R6: Zone values 6 and 7 act as zones 0 and 1.
- R7: Tick t and tick PERIOD-1-t of a period carry the same vector. Each dwell-driven vector occupies floor(dwell/2) ticks in each half.
- R8: Half-dwells are accumulated from the period edge inward and capped at PERIOD/2. When the dwells overrun the period, the innermost vectors are shortened or dropped, and the period still lasts exactly PERIOD cycles.
- R9: A command sampled with `cmd_valid` high replaces any earlier pending one. It is applied at the next period start. Without a new command, the last applied command repeats every period.
- R10: Synchronous active-high `rst` drives u1 on the next edge and stops the timer. The outputs stay u1 until a command arrives. After the first `cmd_valid` edge, tick 0 of the first period appears on the outputs two edges later, and periods follow every PERIOD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Capture the command fields on this edge |
| cmd_region | input | 2 | 0 low, 1 high, 2 over voltage, 3 treated as high |
| cmd_zone | input | 3 | Zone or sector, 0..5 (6, 7 fold to 0, 1) |
| cmd_sub | input | 2 | Over-voltage sub-zone |
| cmd_dw0 | input | TW | Full-period dwell of the outermost vector, ticks |
| cmd_dw1 | input | TW | Full-period dwell of the second vector, ticks |
| cmd_dw2 | input | TW | Full-period dwell of the third vector, ticks |
| sw_o | output | 3 | Upper switch commands {A,B,C} |
| vec_o | output | 3 | Active vector index, 0..5 for u1..u6 |
| cm_o | output | 2 | Common-mode sign, 2'b01 = +1, 2'b11 = -1 |

## Verification
The bench goes after dwell sets that overrun the half period. A design that fails to cap them would run past the period end or wrap its boundaries and emit the wrong vector. It also checks odd dwells and zero-length vectors, where a wrong halving breaks the mirror symmetry. Commands are changed in the middle of a period: a design that applies them at once would change the pattern partway through a period. Further cases are zone values 6 and 7, the reserved region code and the clamped over-voltage sub-zones, where a sloppy decode could choose an out-of-range index and so output a zero switching state.

// File: rtl/zvf_pkg.sv
package zvf_pkg;

  typedef enum logic [1:0] {
    RG_LOW  = 2'd0,
    RG_HIGH = 2'd1,
    RG_OVER = 2'd2,
    RG_RSVD = 2'd3
  } region_e;

  typedef logic [2:0] vidx_t;

  typedef struct packed {
    region_e     region;
    logic [2:0]  zone;
    logic [1:0]  sub;
  } mode_t;

  // index rotation modulo six, both operands in 0..5
  function automatic vidx_t vrot(input vidx_t a, input logic [2:0] k);
    logic [3:0] s;
    s = {1'b0, a} + {1'b0, k};
    if (s >= 4'd6) s = s - 4'd6;
    return s[2:0];
  endfunction

  // upper-leg pattern {A,B,C} for an active vector index
  function automatic logic [2:0] vbits(input vidx_t v);
    logic [2:0] b;
    case (v)
      3'd0:    b = 3'b100;
      3'd1:    b = 3'b110;
      3'd2:    b = 3'b010;
      3'd3:    b = 3'b011;
      3'd4:    b = 3'b001;
      3'd5:    b = 3'b101;
      default: b = 3'b100;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/zvf_cmd_latch.sv
module zvf_cmd_latch #(
  parameter int TW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  zvf_pkg::mode_t      mode_i,
  input  logic [2:0][TW-1:0]  dw_i,
  input  logic                wrap_i,
  output logic                run_o,
  output zvf_pkg::mode_t      mode_o,
  output logic [2:0][TW-1:0]  dw_o
);

  zvf_pkg::mode_t      pend_mode;
  logic [2:0][TW-1:0]  pend_dw;
  logic                have_pend;
  logic                take;

  // first start, or every period boundary once running
  assign take = (!run_o && have_pend) || wrap_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_pend <= 1'b0;
      run_o     <= 1'b0;
      pend_mode <= '0;
      pend_dw   <= '0;
      mode_o    <= '0;
      dw_o      <= '0;
    end else begin
      if (cmd_valid) begin
        pend_mode <= mode_i;
        pend_dw   <= dw_i;
        have_pend <= 1'b1;
      end
      if (take) begin
        mode_o <= pend_mode;
        dw_o   <= pend_dw;
      end
      if (have_pend) run_o <= 1'b1;
    end
  end

endmodule

// File: rtl/zvf_period_timer.sv
module zvf_period_timer #(
  parameter int PERIOD = 20000,
  localparam int TICK_W = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  output logic [TICK_W-1:0] tick_o,
  output logic              wrap_o
);

  localparam logic [TICK_W-1:0] LAST = TICK_W'(PERIOD - 1);

  assign wrap_o = run_i && (tick_o == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) tick_o <= '0;
    else if (wrap_o)   tick_o <= '0;
    else               tick_o <= tick_o + 1'b1;
  end

endmodule

// File: rtl/zvf_vector_select.sv
module zvf_vector_select #(
  parameter int PERIOD = 20000,
  parameter int TW     = 16,
  localparam int TICK_W = $clog2(PERIOD),
  localparam int CW     = TW + 2
) (
  input  zvf_pkg::mode_t      mode_i,
  input  logic [2:0][TW-1:0]  dw_i,
  input  logic [TICK_W-1:0]   tick_i,
  output zvf_pkg::vidx_t      vec_o
);
  import zvf_pkg::*;

  localparam int HALF = PERIOD / 2;
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  vidx_t               zf;
  vidx_t [3:0]         seq;
  logic  [2:0]         nvec;
  logic  [2:0][CW-1:0] cum;
  logic  [2:0][CW-1:0] bnd;
  logic  [TICK_W-1:0]  xpos;
  logic  [CW-1:0]      xe;

  assign zf = (mode_i.zone >= 3'd6) ? (mode_i.zone - 3'd6) : mode_i.zone;

  // vector set and edge-to-centre order per region
  always_comb begin
    nvec = 3'd1;
    seq  = {4{zf}};
    case (mode_i.region)
      RG_LOW: begin
        nvec   = 3'd4;
        seq[0] = vrot(zf, 3'd5);
        seq[1] = zf;
        seq[2] = vrot(zf, 3'd1);
        seq[3] = vrot(zf, 3'd2);
      end
      RG_OVER: begin
        case (mode_i.sub)
          2'd0: begin
            nvec   = 3'd2;
            seq[0] = zf;
            seq[1] = vrot(zf, 3'd1);
            seq[2] = vrot(zf, 3'd1);
            seq[3] = vrot(zf, 3'd1);
          end
          2'd1: begin
            nvec = 3'd1;
            seq  = {4{vrot(zf, 3'd1)}};
          end
          default: begin
            nvec = 3'd1;
            seq  = {4{zf}};
          end
        endcase
      end
      default: begin
        nvec   = 3'd3;
        seq[0] = vrot(zf, 3'd5);
        seq[1] = zf;
        seq[2] = vrot(zf, 3'd1);
        seq[3] = vrot(zf, 3'd1);
      end
    endcase
  end

  // half-period boundaries, accumulated from the edge and capped at HALF
  for (genvar k = 0; k < 3; k++) begin : g_bnd
    logic [CW-1:0] half_k;
    logic [CW-1:0] prev_k;
    logic [CW-1:0] cap_k;
    assign half_k = CW'(dw_i[k] >> 1);
    if (k == 0) begin : g_first
      assign cum[k]  = half_k;
      assign prev_k  = '0;
    end else begin : g_rest
      assign cum[k]  = cum[k-1] + half_k;
      assign prev_k  = bnd[k-1];
    end
    assign cap_k  = (cum[k] > HALF_C) ? HALF_C : cum[k];
    assign bnd[k] = ((3'(k) + 3'd1) < nvec) ? cap_k : prev_k;
  end

  // fold the second half onto the first for a mirrored pattern
  assign xpos = (tick_i < TICK_W'(HALF)) ? tick_i : (TICK_W'(PERIOD - 1) - tick_i);
  assign xe   = CW'(xpos);

  always_comb begin
    if      (xe < bnd[0]) vec_o = seq[0];
    else if (xe < bnd[1]) vec_o = seq[1];
    else if (xe < bnd[2]) vec_o = seq[2];
    else                  vec_o = seq[3];
  end

endmodule

// File: rtl/zvf_pwm_seq.sv
module zvf_pwm_seq #(
  parameter int PERIOD = 20000,
  parameter int TW     = 16,
  localparam int TICK_W = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_region,
  input  logic [2:0]    cmd_zone,
  input  logic [1:0]    cmd_sub,
  input  logic [TW-1:0] cmd_dw0,
  input  logic [TW-1:0] cmd_dw1,
  input  logic [TW-1:0] cmd_dw2,
  output logic [2:0]    sw_o,
  output logic [2:0]    vec_o,
  output logic [1:0]    cm_o
);
  import zvf_pkg::*;

  mode_t               cmd_mode;
  mode_t               act_mode;
  logic [2:0][TW-1:0]  cmd_dw;
  logic [2:0][TW-1:0]  act_dw;
  logic                run;
  logic                wrap;
  logic [TICK_W-1:0]   tick;
  vidx_t               sel_vec;
  vidx_t               nxt_vec;

  assign cmd_mode.region = region_e'(cmd_region);
  assign cmd_mode.zone   = cmd_zone;
  assign cmd_mode.sub    = cmd_sub;
  assign cmd_dw          = {cmd_dw2, cmd_dw1, cmd_dw0};

  zvf_cmd_latch #(.TW(TW)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .mode_i    (cmd_mode),
    .dw_i      (cmd_dw),
    .wrap_i    (wrap),
    .run_o     (run),
    .mode_o    (act_mode),
    .dw_o      (act_dw)
  );

  zvf_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .tick_o (tick),
    .wrap_o (wrap)
  );

  zvf_vector_select #(.PERIOD(PERIOD), .TW(TW)) u_sel (
    .mode_i (act_mode),
    .dw_i   (act_dw),
    .tick_i (tick),
    .vec_o  (sel_vec)
  );

  assign nxt_vec = run ? sel_vec : vidx_t'(3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o <= 3'd0;
      sw_o  <= 3'b100;
      cm_o  <= 2'b01;
    end else begin
      vec_o <= nxt_vec;
      sw_o  <= vbits(nxt_vec);
      cm_o  <= nxt_vec[0] ? 2'b11 : 2'b01;
    end
  end

endmodule

// File: rtl/zvf_pwm_seq_chk.sv
module zvf_pwm_seq_chk #(
  parameter int PERIOD = 20000,
  parameter int TICK_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        sw,
  input logic [1:0]        cm,
  input logic [2:0]        vec,
  input logic              run,
  input logic [TICK_W-1:0] tick,
  input zvf_pkg::mode_t    mode
);
  import zvf_pkg::*;

  // R1
  no_zero_state_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(sw) >= 1) && ($countones(sw) <= 2));

  // R2
  cm_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (cm == 2'b01 || cm == 2'b11) && (($countones(sw) == 1) == (cm == 2'b01)));

  // R5
  ov_clamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick != '0 && mode.region == RG_OVER && mode.sub != 2'd0) |=> $stable(sw));

  // R8
  tick_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(tick) < PERIOD);

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick != TICK_W'(PERIOD - 1)) |=> $stable(mode));

  // R10
  idle_u1_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (vec == 3'd0 && sw == 3'b100));

endmodule

bind zvf_pwm_seq zvf_pwm_seq_chk #(.PERIOD(PERIOD), .TICK_W(TICK_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .sw   (sw_o),
  .cm   (cm_o),
  .vec  (vec_o),
  .run  (run),
  .tick (tick),
  .mode (act_mode)
);

// File: tb/zvf_pwm_seq_tb.sv
module zvf_pwm_seq_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int P  = 64;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_region = '0;
  logic [2:0]    cmd_zone = '0;
  logic [1:0]    cmd_sub = '0;
  logic [TW-1:0] cmd_dw0 = '0, cmd_dw1 = '0, cmd_dw2 = '0;
  logic [2:0]    sw_o, vec_o;
  logic [1:0]    cm_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string phase = "R10";

  always #2.5 clk = ~clk;

  zvf_pwm_seq #(.PERIOD(P), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_region(cmd_region),
    .cmd_zone(cmd_zone), .cmd_sub(cmd_sub), .cmd_dw0(cmd_dw0),
    .cmd_dw1(cmd_dw1), .cmd_dw2(cmd_dw2), .sw_o(sw_o), .vec_o(vec_o), .cm_o(cm_o));

  // expected switch pattern from leg membership (R2)
  function automatic logic [2:0] leg_bits(int v);
    logic a, b, c;
    a = (v == 0 || v == 1 || v == 5);
    b = (v == 1 || v == 2 || v == 3);
    c = (v == 3 || v == 4 || v == 5);
    return {a, b, c};
  endfunction

  // expected vector for tick t of a period (R3..R8)
  function automatic int ref_vec(int t, int rg, int zn, int sb, int a, int b, int c);
    int z, n, x, acc;
    int sq [4];
    int hd [3];
    z = zn % 6;
    x = (t < P/2) ? t : P - 1 - t;
    hd[0] = a / 2; hd[1] = b / 2; hd[2] = c / 2;
    if (rg == 0) begin
      n = 4; sq[0] = (z+5)%6; sq[1] = z; sq[2] = (z+1)%6; sq[3] = (z+2)%6;
    end else if (rg == 2) begin
      if (sb == 0) begin n = 2; sq[0] = z; sq[1] = (z+1)%6; end
      else if (sb == 1) begin n = 1; sq[0] = (z+1)%6; end
      else begin n = 1; sq[0] = z; end
    end else begin
      n = 3; sq[0] = (z+5)%6; sq[1] = z; sq[2] = (z+1)%6;
    end
    acc = 0;
    for (int k = 0; k < n - 1; k++) begin
      acc += hd[k];
      if (x < acc) return sq[k];
    end
    return sq[n-1];
  endfunction

  // model state, advanced once per rising edge
  int m_run = 0, m_have = 0, m_t = 0;
  int m_rg, m_zn, m_sb, m_a, m_b, m_c;
  int q_rg, q_zn, q_sb, q_a, q_b, q_c;
  int p_rst = 1, p_val = 0, p_rg, p_zn, p_sb, p_a, p_b, p_c;

  always @(negedge clk) begin
    int exp_v;
    string tag;
    bit wr;
    if (!done) begin
      if (p_rst != 0 || m_run == 0) exp_v = 0;
      else exp_v = ref_vec(m_t, m_rg, m_zn, m_sb, m_a, m_b, m_c);
      if (p_rst != 0 || m_run == 0) tag = "R10";
      else if (m_rg == 0) tag = "R3";
      else if (m_rg == 2) tag = "R5";
      else tag = "R4";
      if (p_rst != 0) begin
        m_run = 0; m_have = 0; m_t = 0;
      end else begin
        wr = (m_run != 0) && (m_t == P - 1);
        if ((m_run == 0 && m_have != 0) || wr) begin
          m_rg = q_rg; m_zn = q_zn; m_sb = q_sb; m_a = q_a; m_b = q_b; m_c = q_c;
        end
        if (m_run != 0) m_t = wr ? 0 : m_t + 1;
        if (m_have != 0) m_run = 1;
        if (p_val != 0) begin
          q_rg = p_rg; q_zn = p_zn; q_sb = p_sb; q_a = p_a; q_b = p_b; q_c = p_c;
          m_have = 1;
        end
      end
      checks++;
      if (int'(vec_o) != exp_v) begin
        failures++;
        $display("FAIL %s/%s vec_o=%0d expected %0d", tag, phase, vec_o, exp_v);
      end
      checks++;
      if (sw_o != leg_bits(exp_v)) begin
        failures++;
        $display("FAIL R2/%s sw_o=%b expected %b", phase, sw_o, leg_bits(exp_v));
      end
      checks++;
      if (cm_o != ((exp_v % 2 == 0) ? 2'b01 : 2'b11)) begin
        failures++;
        $display("FAIL R2 cm_o=%b expected %b", cm_o, (exp_v % 2 == 0) ? 2'b01 : 2'b11);
      end
      checks++;
      if (sw_o == 3'b000 || sw_o == 3'b111) begin
        failures++;
        $display("FAIL R1 sw_o=%b expected an active state", sw_o);
      end
      p_rst = rst; p_val = cmd_valid; p_rg = cmd_region; p_zn = cmd_zone;
      p_sb = cmd_sub; p_a = cmd_dw0; p_b = cmd_dw1; p_c = cmd_dw2;
    end
  end

  task automatic tick_n(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(int rg, int zn, int sb, int a, int b, int c);
    @(posedge clk); #1;
    cmd_region = 2'(rg); cmd_zone = 3'(zn); cmd_sub = 2'(sb);
    cmd_dw0 = TW'(a); cmd_dw1 = TW'(b); cmd_dw2 = TW'(c);
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24611));
    tick_n(5);
    rst = 1'b0;
    phase = "R10";
    tick_n(12);
    // every zone of every region, fresh dwells
    phase = "R3";
    for (int z = 0; z < 6; z++) begin send(0, z, 0, 10, 20, 16); tick_n(P); end
    phase = "R4";
    for (int z = 0; z < 6; z++) begin send(1, z, 0, 14, 30, 50); tick_n(P); end
    send(3, 2, 0, 8, 40, 0); tick_n(P);
    phase = "R5";
    for (int s = 0; s < 4; s++) begin send(2, 3, s, 24, 40, 9); tick_n(P + 3); end
    phase = "R6";
    send(0, 6, 0, 12, 12, 12); tick_n(P);
    send(1, 7, 0, 20, 20, 0);  tick_n(P);
    phase = "R7";
    send(0, 4, 0, 7, 0, 13); tick_n(2*P);
    phase = "R8";
    send(0, 1, 0, 40, 40, 40);  tick_n(P);
    send(1, 5, 0, 100, 9, 0);   tick_n(P);
    send(2, 0, 0, 200, 0, 0);   tick_n(P);
    phase = "R9";
    send(0, 2, 0, 6, 6, 6);
    tick_n(20);
    send(1, 4, 0, 30, 10, 0);
    tick_n(5);
    send(2, 1, 1, 0, 0, 0);
    tick_n(3*P);
    phase = "R9";
    for (int i = 0; i < 120; i++) begin
      send($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom_range(0, 80), $urandom_range(0, 80), $urandom_range(0, 80));
      tick_n($urandom_range(1, 100));
    end
    phase = "R10";
    @(posedge clk); #1 rst = 1'b1;
    tick_n(2);
    rst = 1'b0;
    tick_n(10);
    send(0, 0, 0, 16, 16, 16);
    tick_n(P + 4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule